// File: doc/BRIEF.md
# Auxiliary TAP Handoff Controller

This block is the primary test access port of a chip with several subordinate (auxiliary) TAP controllers behind it. It owns the JTAG pins, runs the 16-state TAP sequence on TMS, holds a shift and update instruction register, and offers a one-bit bypass data path. Each auxiliary TAP has its own opcode. When one of those opcodes is loaded, the selected auxiliary TAP takes over the port. TMS and TDI are forwarded to it, and its TDO is driven out on the primary TDO.

During a handoff the primary sequencer keeps tracking TMS, so it always knows where the auxiliary TAP is in its own sequence. The port returns to the primary controller at the Update-DR state, but only when Pause-DR has been visited since the handoff began. When the port returns, the instruction register holds the bypass opcode. Auxiliary TAPs that do not own the port see TMS held low, so they park in Run-Test/Idle. All auxiliary TAPs share the primary TCK. The host is expected to leave Update-IR towards Run-Test/Idle when it starts a handoff.

Top module: `tap_handoff_top`

## Requirements
- R1: A low `trst_n` at a rising `tck` puts the sequencer in Test-Logic-Reset and loads the all-ones (bypass) opcode. After that edge, `aux_grant`, `aux_tms` and `aux_tdi` are all zero and `tdo` is 0, including when a handoff was active.
- R2: With the default IR_W=5 and AUX_OP_BASE=16, the opcode AUX_OP_BASE+k (0 <= k < N_AUX) is loaded at the edge that leaves Update-IR. From then on `aux_grant` is one-hot with bit k set.
- R3: While auxiliary k is granted, `aux_tms[k]` follows `tms` and `aux_tdi[k]` follows `tdi`. Every other auxiliary sees 0 on both, so it stays in Run-Test/Idle. The granted auxiliary moves through the same TAP states as the primary sequencer.
- R4: While auxiliary k is granted, `tdo` equals `aux_tdo[k]` in every state.
- R5: A handoff ends at the edge that leaves Update-DR if Pause-DR was entered after the handoff started. The instruction register then holds the all-ones bypass opcode.
- R6: Reaching Update-DR without a visit to Pause-DR during the current handoff leaves the grant in place. A pause seen in an earlier handoff does not count.
- R7: Entering Test-Logic-Reset, for example through five TMS-high clocks, drops the grant in that same state.
- R8: With no grant, Shift-IR drives the instruction shift register LSB on `tdo`, with a capture value of binary ...00001 shifted out LSB first. Shift-DR uses a one-bit bypass stage that captures 0 and delays TDI by one clock. In every other state `tdo` is 0.
- R9: Any opcode outside AUX_OP_BASE..AUX_OP_BASE+N_AUX-1, including AUX_OP_BASE+N_AUX, grants nothing and selects the bypass stage.
- R10: An instruction register scan made during a handoff does not change the instruction register. The grant keeps its auxiliary even when a different auxiliary opcode is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, also shared by all auxiliary TAPs |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Test mode select from the pin |
| tdi | input | 1 | Serial test data from the pin |
| tdo | output | 1 | Serial test data to the pin |
| aux_tdo | input | N_AUX | Serial data from each auxiliary TAP |
| aux_tms | output | N_AUX | Forwarded or held-low TMS per auxiliary TAP |
| aux_tdi | output | N_AUX | Forwarded TDI per auxiliary TAP, 0 when not granted |
| aux_grant | output | N_AUX | One-hot: auxiliary TAP that currently owns the port |

## Verification
The in-line assertions watch the following on every clock:
- `aux_grant` stays one-hot-or-zero.
- The grant holds steady through every state except Update-DR and the step into Test-Logic-Reset.
- The grant drops after Update-DR when a pause was seen, and stays after Update-DR without one.
- The instruction register changes only at Update-IR, in Test-Logic-Reset or on a release.
- Test-Logic-Reset is sticky under TMS high.

Only the bench's scenarios can show the rest. Data really travels end to end through the modelled auxiliary shift registers. Auxiliary TAPs stay in step with the primary sequencer across a handoff and park in Run-Test/Idle afterwards. Out-of-range opcodes fall back to bypass, and a pause from an earlier handoff is not carried into the next one.

// File: rtl/tap_hand_pkg.sv
// Package: shared TAP state type and next-state function.
// Assumes the standard 16-state TAP sequence advanced by TMS at rising TCK.
package tap_hand_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    // Successor of state s under TMS value m.
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        case (s)
            TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
            default:   n = m ? TS_SEL_DR : TS_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_seq.sv
// Module: tap_seq
// TAP state sequencer. It keeps running during a handoff, because the pin TMS
// is the same signal that is forwarded to the auxiliary TAP.
// Assumes: synchronous active-low reset sampled on rising tck.
module tap_seq
    import tap_hand_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    // Advance the TAP sequence on every rising edge.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= tap_next(state, tms);
    end

    // Test-Logic-Reset holds while TMS stays high.
    assert_tlr_hold_R7: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET && tms) |=> (state == TS_RESET));

endmodule

// File: rtl/tap_instr.sv
// Module: tap_instr
// Instruction shift and update register, plus the one-bit bypass stage.
// Assumes: 'hold' is high while an auxiliary TAP owns the port. 'release_i' is
// a one-cycle pulse in Update-DR that hands the port back.
module tap_instr
    import tap_hand_pkg::*;
#(
    parameter int IR_W = 5
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    input  logic            hold,
    input  logic            release_i,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb,
    output logic            byp_q
);

    localparam logic [IR_W-1:0] IR_BYPASS = '1;
    localparam logic [IR_W-1:0] IR_CAPT   = IR_W'(1);

    logic [IR_W-1:0] ir_sr;

    // Instruction shift stage: capture ...01, then shift TDI in at the MSB.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            ir_sr <= IR_CAPT;
        end else if (!hold && state == TS_CAP_IR) begin
            ir_sr <= IR_CAPT;
        end else if (!hold && state == TS_SHF_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    // Instruction update stage: bypass on reset or release, shifted value at Update-IR.
    always_ff @(posedge tck) begin
        if (!rst_n || state == TS_RESET || release_i) begin
            ir_q <= IR_BYPASS;
        end else if (!hold && state == TS_UPD_IR) begin
            ir_q <= ir_sr;
        end
    end

    // Bypass stage: captures 0, then delays TDI by one clock.
    always_ff @(posedge tck) begin
        if (!rst_n)                  byp_q <= 1'b0;
        else if (state == TS_CAP_DR) byp_q <= 1'b0;
        else if (state == TS_SHF_DR) byp_q <= tdi;
    end

    assign ir_lsb = ir_sr[0];

    // The instruction changes only at Update-IR, in reset, or on a release.
    assert_ir_quiet_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (state != TS_UPD_IR && state != TS_RESET && !release_i) |=> $stable(ir_q));

    // An Update-IR during a handoff is ignored.
    assert_ir_locked_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (hold && state == TS_UPD_IR && !release_i) |=> $stable(ir_q));

endmodule

// File: rtl/aux_switch.sv
// Module: aux_switch
// Decodes the auxiliary opcodes, routes TMS, TDI and TDO to the granted
// auxiliary TAP, and keeps the "pause seen" flag that ends a handoff.
// Assumes: ir_q is the updated instruction and state is the primary sequencer.
module aux_switch
    import tap_hand_pkg::*;
#(
    parameter int N_AUX       = 3,
    parameter int IR_W        = 5,
    parameter int AUX_OP_BASE = 16
) (
    input  logic             tck,
    input  logic             rst_n,
    input  tap_state_t       state,
    input  logic [IR_W-1:0]  ir_q,
    input  logic             tms,
    input  logic             tdi,
    input  logic [N_AUX-1:0] aux_tdo,
    output logic             active,
    output logic             release_o,
    output logic [N_AUX-1:0] aux_tms,
    output logic [N_AUX-1:0] aux_tdi,
    output logic [N_AUX-1:0] aux_grant,
    output logic             tdo_aux
);

    logic [N_AUX-1:0] hit;
    logic             pause_q;

    // One opcode comparator per auxiliary TAP.
    for (genvar k = 0; k < N_AUX; k++) begin : g_dec
        localparam logic [IR_W-1:0] OP_K = IR_W'(AUX_OP_BASE + k);
        assign hit[k] = (ir_q == OP_K);
    end

    // The grant drops as soon as the sequencer sits in Test-Logic-Reset.
    always_comb begin
        aux_grant = (state == TS_RESET) ? '0 : hit;
    end

    assign active    = |aux_grant;
    assign aux_tms   = aux_grant & {N_AUX{tms}};
    assign aux_tdi   = aux_grant & {N_AUX{tdi}};
    assign tdo_aux   = |(aux_grant & aux_tdo);
    assign release_o = active && (state == TS_UPD_DR) && pause_q;

    // Pause flag: set in Pause-DR during a handoff; cleared at start, release or reset.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            pause_q <= 1'b0;
        end else if (active && state == TS_PAU_DR) begin
            pause_q <= 1'b1;
        end else if (release_o || state == TS_RESET || (!active && state == TS_UPD_IR)) begin
            pause_q <= 1'b0;
        end
    end

    // At most one auxiliary owns the port.
    assert_one_owner_R2: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(aux_grant));

    // Update-DR after a pause hands the port back.
    assert_release_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (active && state == TS_UPD_DR && pause_q) |=> !active);

    // Update-DR without a pause keeps the same owner.
    assert_no_release_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (active && state == TS_UPD_DR && !pause_q) |=> (active && $stable(aux_grant)));

    // Outside Update-DR and the step into reset, the owner does not change.
    assert_owner_steady_R10: assert property (@(posedge tck) disable iff (!rst_n)
        (active && state != TS_UPD_DR && !(state == TS_SEL_IR && tms))
            |=> $stable(aux_grant));

    // Once the sequencer has been in reset, no handoff is active.
    assert_reset_cancel_R7: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET) |=> !active);

endmodule

// File: rtl/tap_handoff_top.sv
// Module: tap_handoff_top
// Primary TAP with handoff of the pins to one of N_AUX auxiliary TAPs.
// Assumes: auxiliary TAPs share tck and sit in Run-Test/Idle when a handoff
// starts, and the host leaves Update-IR towards Run-Test/Idle to start one.
module tap_handoff_top
    import tap_hand_pkg::*;
#(
    parameter int N_AUX       = 3,
    parameter int IR_W        = 5,
    parameter int AUX_OP_BASE = 16
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_AUX-1:0] aux_tdo,
    output logic [N_AUX-1:0] aux_tms,
    output logic [N_AUX-1:0] aux_tdi,
    output logic [N_AUX-1:0] aux_grant
);

    tap_state_t      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            byp_q;
    logic            active;
    logic            release_p;
    logic            tdo_aux;

    tap_seq u_seq (
        .tck   (tck),
        .rst_n (trst_n),
        .tms   (tms),
        .state (state)
    );

    tap_instr #(.IR_W(IR_W)) u_instr (
        .tck       (tck),
        .rst_n     (trst_n),
        .state     (state),
        .tdi       (tdi),
        .hold      (active),
        .release_i (release_p),
        .ir_q      (ir_q),
        .ir_lsb    (ir_lsb),
        .byp_q     (byp_q)
    );

    aux_switch #(
        .N_AUX       (N_AUX),
        .IR_W        (IR_W),
        .AUX_OP_BASE (AUX_OP_BASE)
    ) u_switch (
        .tck       (tck),
        .rst_n     (trst_n),
        .state     (state),
        .ir_q      (ir_q),
        .tms       (tms),
        .tdi       (tdi),
        .aux_tdo   (aux_tdo),
        .active    (active),
        .release_o (release_p),
        .aux_tms   (aux_tms),
        .aux_tdi   (aux_tdi),
        .aux_grant (aux_grant),
        .tdo_aux   (tdo_aux)
    );

    // TDO select: auxiliary during a handoff, otherwise IR or bypass stage while shifting.
    always_comb begin
        if (active)                  tdo = tdo_aux;
        else if (state == TS_SHF_IR) tdo = ir_lsb;
        else if (state == TS_SHF_DR) tdo = byp_q;
        else                         tdo = 1'b0;
    end

endmodule

// File: tb/tap_handoff_top_bench.sv
module tap_handoff_top_bench;
    localparam int N = 3;
    localparam int W = 5;
    localparam int BASE = 16;
    localparam int ONES = (1 << W) - 1;

    // Bench-side state codes
    localparam int ST_TLR = 0, ST_RTI = 1, ST_SDS = 2, ST_CDR = 3, ST_SDR = 4, ST_E1D = 5,
                   ST_PDR = 6, ST_E2D = 7, ST_UDR = 8, ST_SIS = 9, ST_CIR = 10, ST_SIR = 11,
                   ST_E1I = 12, ST_PIR = 13, ST_E2I = 14, ST_UIR = 15;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo;
    logic [N-1:0] aux_tdo, aux_tms, aux_tdi, aux_grant;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 tck = ~tck;

    tap_handoff_top #(.N_AUX(N), .IR_W(W), .AUX_OP_BASE(BASE)) u_tap_handoff_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .aux_tdo(aux_tdo), .aux_tms(aux_tms), .aux_tdi(aux_tdi), .aux_grant(aux_grant)
    );

    function automatic int nxt(int s, bit m);
        case (s)
            ST_TLR: return m ? ST_TLR : ST_RTI;
            ST_RTI: return m ? ST_SDS : ST_RTI;
            ST_SDS: return m ? ST_SIS : ST_CDR;
            ST_CDR: return m ? ST_E1D : ST_SDR;
            ST_SDR: return m ? ST_E1D : ST_SDR;
            ST_E1D: return m ? ST_UDR : ST_PDR;
            ST_PDR: return m ? ST_E2D : ST_PDR;
            ST_E2D: return m ? ST_UDR : ST_SDR;
            ST_UDR: return m ? ST_SDS : ST_RTI;
            ST_SIS: return m ? ST_TLR : ST_CIR;
            ST_CIR: return m ? ST_E1I : ST_SIR;
            ST_SIR: return m ? ST_E1I : ST_SIR;
            ST_E1I: return m ? ST_UIR : ST_PIR;
            ST_PIR: return m ? ST_E2I : ST_PIR;
            ST_E2I: return m ? ST_UIR : ST_SIR;
            default: return m ? ST_SDS : ST_RTI;
        endcase
    endfunction

    function automatic int aux_len(int k);
        return 5 + 3 * k;
    endfunction

    function automatic int aux_cap(int k);
        return (32'h2D5 ^ (k * 32'h13)) & ((1 << aux_len(k)) - 1);
    endfunction

    // Reference model state
    int m_st = ST_TLR, m_ir = ONES, m_irsr = 1, m_pause = 0, m_byp = 0;
    int a_st [N];
    int a_sr [N];

    function automatic int m_sel();
        if (m_st != ST_TLR && m_ir >= BASE && m_ir < BASE + N) return m_ir - BASE;
        return -1;
    endfunction

    always_comb begin
        for (int k = 0; k < N; k++) aux_tdo[k] = a_sr[k][0];
    end

    // Reference model of the block
    always @(posedge tck) begin : ref_model
        int s;
        int rel;
        s = m_sel();
        rel = (s >= 0 && m_st == ST_UDR && m_pause != 0) ? 1 : 0;
        if (!trst_n) begin
            m_st <= ST_TLR; m_ir <= ONES; m_pause <= 0; m_irsr <= 1; m_byp <= 0;
        end else begin
            if (s < 0 && m_st == ST_CIR) m_irsr <= 1;
            else if (s < 0 && m_st == ST_SIR) m_irsr <= (m_irsr >> 1) | (int'(tdi) << (W - 1));
            if (m_st == ST_CDR) m_byp <= 0;
            else if (m_st == ST_SDR) m_byp <= int'(tdi);
            if (m_st == ST_TLR || rel != 0) m_ir <= ONES;
            else if (s < 0 && m_st == ST_UIR) m_ir <= m_irsr;
            if (s >= 0 && m_st == ST_PDR) m_pause <= 1;
            else if (rel != 0 || m_st == ST_TLR || (s < 0 && m_st == ST_UIR)) m_pause <= 0;
            m_st <= nxt(m_st, tms);
        end
    end

    // Auxiliary TAP models: TAP sequence plus a plain data shift register
    always @(posedge tck) begin
        for (int k = 0; k < N; k++) begin
            if (!trst_n) begin
                a_st[k] <= ST_RTI;
                a_sr[k] <= aux_cap(k);
            end else begin
                if (a_st[k] == ST_CDR) a_sr[k] <= aux_cap(k);
                else if (a_st[k] == ST_SDR)
                    a_sr[k] <= (a_sr[k] >> 1) | (int'(aux_tdi[k]) << (aux_len(k) - 1));
                a_st[k] <= nxt(a_st[k], aux_tms[k]);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge tck) begin : compare
        int s;
        logic [N-1:0] eg, et, ed;
        logic ex;
        if (trst_n && !done) begin
            s = m_sel();
            eg = '0; et = '0; ed = '0;
            if (s >= 0) begin
                eg[s] = 1'b1; et[s] = tms; ed[s] = tdi;
                ex = a_sr[s][0];
            end else if (m_st == ST_SIR) ex = m_irsr[0];
            else if (m_st == ST_SDR) ex = m_byp[0];
            else ex = 1'b0;
            chk("R2 aux_grant", 32'(aux_grant), 32'(eg));
            chk("R3 aux_tms", 32'(aux_tms), 32'(et));
            chk("R3 aux_tdi", 32'(aux_tdi), 32'(ed));
            chk(s >= 0 ? "R4 tdo from auxiliary" : "R8 tdo primary path", 32'(tdo), 32'(ex));
            if (s >= 0) chk("R3 granted auxiliary in step", a_st[s], m_st);
        end
    end

    task automatic tick(bit m, bit d);
        tms = m; tdi = d;
        @(negedge tck); #1;
    endtask

    task automatic load_ir(int code);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < W; i++) tick(i == W - 1, (code >> i) & 1);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(int n, int data, bit pause);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) tick(i == n - 1, (data >> i) & 1);
        if (pause) begin tick(0, 0); tick(0, 0); tick(1, 0); end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        done = 1;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge tck); #1;
        repeat (3) @(negedge tck); #1;
        // R1: reset state
        chk("R1 grant in reset", 32'(aux_grant), 0);
        chk("R1 aux_tms in reset", 32'(aux_tms), 0);
        chk("R1 tdo in reset", 32'(tdo), 0);
        trst_n = 1'b1;
        tick(0, 0);

        // R8: IR capture and bypass path with no grant
        load_ir(ONES);
        scan_dr(6, 6'b101101, 0);
        chk("R8 no grant under bypass", 32'(aux_grant), 0);

        // R9: opcodes outside the auxiliary range
        load_ir(3);
        chk("R9 opcode 3 grants nothing", 32'(aux_grant), 0);
        scan_dr(5, 5'b10011, 1);
        load_ir(BASE + N);
        chk("R9 opcode just past range", 32'(aux_grant), 0);
        scan_dr(4, 4'b0110, 0);

        // R2, R6, R10, R5 with auxiliary 1
        load_ir(BASE + 1);
        chk("R2 auxiliary 1 granted", 32'(aux_grant), 32'b010);
        chk("R3 auxiliary 0 parked", a_st[0], ST_RTI);
        scan_dr(9, 9'h1A7, 0);
        chk("R6 grant kept without pause", 32'(aux_grant), 32'b010);
        load_ir(BASE + 2);
        chk("R10 IR scan ignored during handoff", 32'(aux_grant), 32'b010);
        scan_dr(7, 7'h55, 1);
        chk("R5 released after pause", 32'(aux_grant), 0);
        chk("R5 auxiliary 1 parked after release", a_st[1], ST_RTI);
        scan_dr(3, 3'b101, 0);

        // R6: pause from an earlier handoff does not carry over
        load_ir(BASE + 1);
        scan_dr(5, 5'b11001, 0);
        chk("R6 stale pause ignored", 32'(aux_grant), 32'b010);
        scan_dr(4, 4'b1001, 1);
        chk("R5 second release", 32'(aux_grant), 0);

        // R7: TMS-high reset cancels a handoff
        load_ir(BASE + 0);
        chk("R2 auxiliary 0 granted", 32'(aux_grant), 32'b001);
        tick(1, 0); tick(1, 0); tick(1, 0);
        chk("R7 grant drops in reset", 32'(aux_grant), 0);
        tick(1, 0); tick(1, 0); tick(0, 0);
        chk("R7 auxiliary 0 parked", a_st[0], ST_RTI);
        chk("R7 still no grant", 32'(aux_grant), 0);

        // R1: trst during a handoff, then auxiliary 2 full cycle
        load_ir(BASE + 2);
        chk("R2 auxiliary 2 granted", 32'(aux_grant), 32'b100);
        scan_dr(11, 11'h5A3, 0);
        trst_n = 1'b0;
        tick(0, 0);
        chk("R1 trst cancels handoff", 32'(aux_grant), 0);
        trst_n = 1'b1;
        tick(0, 0);
        load_ir(BASE + 2);
        scan_dr(11, 11'h2C9, 1);
        chk("R5 auxiliary 2 released", 32'(aux_grant), 0);
        chk("R3 auxiliary 2 parked", a_st[2], ST_RTI);
        scan_dr(4, 4'b1110, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule